// File: doc/BRIEF.md
# Inter-task event register file

This block is a small shared store for messages that tasks send to one another. Every slot carries a valid flag, the sending task's ID, the receiving task's ID and a free-form message word. A post request places a new message in the lowest-numbered empty slot, which the hardware picks. A full flag shows that no slot is left.

A receiving task issues a search with its own ID. The block looks for the lowest-numbered valid slot addressed to that task and returns the sender, the message and the slot number. It can also release that slot in the same operation, so the slot position acts as the priority among pending messages. For every task, a level output stays high while at least one valid slot is addressed to it. This lets a scheduler treat pending mail as an event for that task.

Top module: `evt_msg_file`

## Requirements
- R1: After reset, every slot is empty: `full` is 0, `overflow` is 0, `find_hit` is 0 and all `sync_evt` bits are 0.
- R2: A post stores {valid=1, source, destination, message} in the lowest-numbered slot that is empty after any clear in the same cycle. The slot number is observable later as `find_slot`.
- R3: `full` is 1 exactly when all SLOTS slots hold valid entries. It changes in the cycle after the post or clear that fills or frees the last slot.
- R4: A post while no slot is free is dropped and leaves the stored contents unchanged. `overflow` is 1 for exactly the one cycle after that request.
- R5: A search returns, in the cycle after `find_req`, `find_hit`=1 together with the source, message and slot of the lowest-numbered valid slot whose destination equals `find_task`. Other matching slots have no effect on the result.
- R6: A search that matches no valid slot returns `find_hit`=0 and changes no slot.
- R7: A search with `find_clear`=1 that hits releases the returned slot. Later searches then skip it.
- R8: `sync_evt[t]` is 1 while at least one valid slot has destination t, and is 0 otherwise.
- R9: When a clearing search and a post arrive in the same cycle with the file full, the slot freed by the clear receives the post and `overflow` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| post_req | input | 1 | Store a new message this cycle |
| post_src | input | TASK_W | Sending task ID |
| post_dst | input | TASK_W | Receiving task ID |
| post_msg | input | MSG_W | Message payload |
| find_req | input | 1 | Search for a message this cycle |
| find_task | input | TASK_W | Task ID searched for |
| find_clear | input | 1 | Release the matched slot |
| find_hit | output | 1 | Last search found a slot |
| find_src | output | TASK_W | Sender of the found message |
| find_msg | output | MSG_W | Payload of the found message |
| find_slot | output | SLOT_W | Slot number of the found message |
| full | output | 1 | No slot is free |
| overflow | output | 1 | One-cycle pulse: a post was dropped |
| sync_evt | output | 2**TASK_W | Per-task pending-message level |

## Verification
Search results and the overflow pulse are registered. They are due one clock after the requesting edge. `full` and `sync_evt` follow the stored slots, so they change after the same edge that writes or releases a slot. The bench drives every request on the falling edge and holds it across one rising edge. It then samples all outputs at the following falling edge, half a period after the update. An idle cycle is inserted before each check that an overflow pulse has ended.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int DEF_TASK_W = 3;
    localparam int DEF_MSG_W  = 8;
    localparam int DEF_SLOTS  = 8;

    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction
endpackage

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
        grant = '0;
        if (found) grant[idx] = 1'b1;
    end
endmodule

// File: rtl/evt_dst_match.sv
module evt_dst_match #(
    parameter int SLOTS  = 8,
    parameter int TASK_W = 3,
    parameter int NT     = 8
) (
    input  logic [SLOTS-1:0]             vld,
    input  logic [SLOTS-1:0][TASK_W-1:0] dst,
    input  logic [TASK_W-1:0]            key,
    output logic [SLOTS-1:0]             hit,
    output logic [NT-1:0]                pend
);
    genvar s, t;
    generate
        for (s = 0; s < SLOTS; s++) begin : g_slot
            assign hit[s] = vld[s] && (dst[s] == key);
        end
        for (t = 0; t < NT; t++) begin : g_task
            logic [SLOTS-1:0] aim;
            for (s = 0; s < SLOTS; s++) begin : g_aim
                assign aim[s] = vld[s] && (dst[s] == TASK_W'(t));
            end
            assign pend[t] = |aim;
        end
    endgenerate
endmodule

// File: rtl/evt_msg_file.sv
module evt_msg_file
    import evt_pkg::*;
#(
    parameter int TASK_W = DEF_TASK_W,
    parameter int MSG_W  = DEF_MSG_W,
    parameter int SLOTS  = DEF_SLOTS,
    localparam int NT     = 1 << TASK_W,
    localparam int SLOT_W = idx_width(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              post_req,
    input  logic [TASK_W-1:0] post_src,
    input  logic [TASK_W-1:0] post_dst,
    input  logic [MSG_W-1:0]  post_msg,
    input  logic              find_req,
    input  logic [TASK_W-1:0] find_task,
    input  logic              find_clear,
    output logic              find_hit,
    output logic [TASK_W-1:0] find_src,
    output logic [MSG_W-1:0]  find_msg,
    output logic [SLOT_W-1:0] find_slot,
    output logic              full,
    output logic              overflow,
    output logic [NT-1:0]     sync_evt
);
    // Slot layout: valid in the top bit, then source, destination, message.
    typedef struct packed {
        logic              vld;
        logic [TASK_W-1:0] src;
        logic [TASK_W-1:0] dst;
        logic [MSG_W-1:0]  msg;
    } slot_t;

    slot_t ent_q [SLOTS];

    logic [SLOTS-1:0]             vld;
    logic [SLOTS-1:0][TASK_W-1:0] dst;
    logic [SLOTS-1:0]             hit_vec;
    logic                         m_found, f_found;
    logic [SLOT_W-1:0]            m_idx, f_idx;
    logic [SLOTS-1:0]             m_grant, f_grant;
    logic [SLOTS-1:0]             clr_mask, free_vec;

    logic              hit_q, ovf_q;
    logic [TASK_W-1:0] src_q;
    logic [MSG_W-1:0]  msg_q;
    logic [SLOT_W-1:0] slot_q;

    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_unpack
            assign vld[g] = ent_q[g].vld;
            assign dst[g] = ent_q[g].dst;
        end
    endgenerate

    evt_dst_match #(.SLOTS(SLOTS), .TASK_W(TASK_W), .NT(NT)) u_match (
        .vld(vld), .dst(dst), .key(find_task), .hit(hit_vec), .pend(sync_evt)
    );

    evt_prio_pick #(.N(SLOTS), .IW(SLOT_W)) u_find_pick (
        .req(hit_vec), .found(m_found), .idx(m_idx), .grant(m_grant)
    );

    // A clear in this cycle frees its slot before allocation looks.
    assign clr_mask = (find_req && find_clear && m_found) ? m_grant : '0;
    assign free_vec = ~(vld & ~clr_mask);

    evt_prio_pick #(.N(SLOTS), .IW(SLOT_W)) u_free_pick (
        .req(free_vec), .found(f_found), .idx(f_idx), .grant(f_grant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) ent_q[i] <= '0;
            hit_q  <= 1'b0;
            ovf_q  <= 1'b0;
            src_q  <= '0;
            msg_q  <= '0;
            slot_q <= '0;
        end else begin
            for (int i = 0; i < SLOTS; i++) begin
                if (clr_mask[i]) ent_q[i].vld <= 1'b0;
                if (post_req && f_grant[i])
                    ent_q[i] <= '{vld: 1'b1, src: post_src, dst: post_dst, msg: post_msg};
            end
            ovf_q <= post_req && !f_found;
            hit_q <= find_req && m_found;
            if (find_req && m_found) begin
                src_q  <= ent_q[m_idx].src;
                msg_q  <= ent_q[m_idx].msg;
                slot_q <= m_idx;
            end
        end
    end

    assign full      = &vld;
    assign overflow  = ovf_q;
    assign find_hit  = hit_q;
    assign find_src  = src_q;
    assign find_msg  = msg_q;
    assign find_slot = slot_q;
endmodule

// File: rtl/evt_msg_file_chk.sv
module evt_msg_file_chk #(
    parameter int TASK_W = 3,
    parameter int SLOTS  = 8,
    localparam int NT = 1 << TASK_W
) (
    input logic              clk,
    input logic              rst,
    input logic              post_req,
    input logic              find_req,
    input logic              find_clear,
    input logic [TASK_W-1:0] find_task,
    input logic              full,
    input logic              overflow,
    input logic              find_hit,
    input logic [NT-1:0]     sync_evt,
    input logic [SLOTS-1:0]  vld
);
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vld == '0 && !overflow && !find_hit));

    assert_full_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (full && post_req && !find_req) |=> (overflow && full));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (post_req && !full) |=> !overflow);

    assert_hit_pending_R5: assert property (@(posedge clk) disable iff (rst)
        (find_req && sync_evt[find_task]) |=> find_hit);

    assert_miss_R6: assert property (@(posedge clk) disable iff (rst)
        (find_req && !sync_evt[find_task]) |=> (!find_hit && $stable(vld)));

    assert_clear_one_R7: assert property (@(posedge clk) disable iff (rst)
        (find_req && find_clear && sync_evt[find_task] && !post_req) |=>
        ($countones(vld) == $past($countones(vld)) - 1));

    assert_sync_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (vld == '0) |-> (sync_evt == '0));
endmodule

bind evt_msg_file evt_msg_file_chk #(.TASK_W(TASK_W), .SLOTS(SLOTS)) u_chk (
    .clk(clk), .rst(rst), .post_req(post_req), .find_req(find_req),
    .find_clear(find_clear), .find_task(find_task), .full(full),
    .overflow(overflow), .find_hit(find_hit), .sync_evt(sync_evt), .vld(vld)
);

// File: tb/evt_msg_file_test.sv
`timescale 1ns/1ps
module evt_msg_file_test;
    localparam int TW = 3;
    localparam int MW = 8;
    localparam int NS = 8;
    localparam int NT = 1 << TW;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          post_req = 1'b0;
    logic [TW-1:0] post_src = '0, post_dst = '0;
    logic [MW-1:0] post_msg = '0;
    logic          find_req = 1'b0, find_clear = 1'b0;
    logic [TW-1:0] find_task = '0;
    logic          find_hit, full, overflow;
    logic [TW-1:0] find_src;
    logic [MW-1:0] find_msg;
    logic [SW-1:0] find_slot;
    logic [NT-1:0] sync_evt;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    evt_msg_file #(.TASK_W(TW), .MSG_W(MW), .SLOTS(NS)) uut (
        .clk(clk), .rst(rst), .post_req(post_req), .post_src(post_src),
        .post_dst(post_dst), .post_msg(post_msg), .find_req(find_req),
        .find_task(find_task), .find_clear(find_clear), .find_hit(find_hit),
        .find_src(find_src), .find_msg(find_msg), .find_slot(find_slot),
        .full(full), .overflow(overflow), .sync_evt(sync_evt)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic post(input int s, input int d, input int m);
        @(negedge clk);
        post_req = 1'b1; post_src = TW'(s); post_dst = TW'(d); post_msg = MW'(m);
        @(negedge clk);
        post_req = 1'b0;
    endtask

    task automatic find_expect(input int t, input bit clr, input bit hit,
                               input int s, input int m, input int slot, input string tag);
        @(negedge clk);
        find_req = 1'b1; find_task = TW'(t); find_clear = clr;
        @(negedge clk);
        find_req = 1'b0; find_clear = 1'b0;
        check({tag, " hit"}, find_hit, hit);
        if (hit) begin
            check({tag, " src"}, find_src, s);
            check({tag, " msg"}, find_msg, m);
            check({tag, " slot"}, find_slot, slot);
        end
    endtask

    task automatic t_reset;
        check("R1 full", full, 0);
        check("R1 overflow", overflow, 0);
        check("R1 hit", find_hit, 0);
        check("R1 sync", sync_evt, 0);
    endtask

    task automatic t_basic;
        post(1, 2, 'hA1);
        post(3, 5, 'hB2);
        post(4, 2, 'hC3);
        check("R8 sync two tasks", sync_evt, 'h24);
        check("R3 not full", full, 0);
        find_expect(2, 0, 1, 1, 'hA1, 0, "R5 lowest match");
        find_expect(2, 1, 1, 1, 'hA1, 0, "R7 clear returns");
        check("R8 sync after clear", sync_evt, 'h24);
        find_expect(2, 0, 1, 4, 'hC3, 2, "R7 skip cleared");
        find_expect(7, 0, 0, 0, 0, 0, "R6 no match");
        check("R6 sync unchanged", sync_evt, 'h24);
    endtask

    task automatic t_reuse;
        post(6, 7, 'hD4);
        find_expect(7, 0, 1, 6, 'hD4, 0, "R2 first free slot");
        check("R8 sync add", sync_evt, 'hA4);
    endtask

    task automatic t_fill;
        for (int i = 3; i < NS; i++) begin
            if (i == NS - 1) check("R3 one free", full, 0);
            post(0, 3, 'h10 + i);
        end
        check("R3 full", full, 1);
        find_expect(3, 0, 1, 0, 'h13, 3, "R5 lowest of many");
    endtask

    task automatic t_overflow;
        post(2, 1, 'hEE);
        check("R4 overflow pulse", overflow, 1);
        @(negedge clk);
        check("R4 pulse one cycle", overflow, 0);
        check("R4 dropped sync", sync_evt[1], 0);
        find_expect(1, 0, 0, 0, 0, 0, "R4 dropped search");
    endtask

    task automatic t_clear_post;
        @(negedge clk);
        find_req = 1'b1; find_task = 3'd5; find_clear = 1'b1;
        post_req = 1'b1; post_src = 3'd5; post_dst = 3'd6; post_msg = 'hF6;
        @(negedge clk);
        find_req = 1'b0; find_clear = 1'b0; post_req = 1'b0;
        check("R9 hit", find_hit, 1);
        check("R9 slot", find_slot, 1);
        check("R9 no overflow", overflow, 0);
        check("R9 still full", full, 1);
        find_expect(6, 0, 1, 5, 'hF6, 1, "R9 reused slot");
        check("R8 sync five gone", sync_evt[5], 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_reuse();
        t_fill();
        t_overflow();
        t_clear_post();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule